// File: doc/BRIEF.md
# Paged Subroutine Call Sequencer

This block carries out far calls and far returns for a 16-bit processor whose code space is reached through a paged program window. A call request supplies a target address, a new page number and the return address. The new page and target can come as immediates, or they can be fetched from memory through a pointer. The block first saves the current page and switches the page register. It then pushes the return address and the saved page onto a downward-growing stack, and ends with a single-cycle jump indication. A return request pops the page byte and then the return address, restores the page register and jumps.

The whole sequence is atomic. While it runs, the block holds an interrupt-block output high, and it ignores any further call or return request. Alongside the sequencer, a combinational translator turns every local address into an extended address. Addresses inside the 16 KB window at 0x8000 to 0xBFFF take the current page in the upper bits. The memory port is single-cycle: read data is valid in the same cycle as the request. Words are big-endian, with the high byte at the lower address.

Top module: `pgcall_seq`

## Requirements
- R1: After reset the page register is 0x00, the stack pointer is 0x00F0, and busy, irq_block, mem_req and jump_valid are all low.
- R2: A direct call accepted at a clock edge runs in four busy cycles. These are a swap cycle, a 16-bit write of the return address at SP-2, an 8-bit write of the old page at the decremented SP-1 (data in bits 7:0, upper bits zero), and a jump cycle. The page register shows the new page from the second busy cycle on.
- R3: An indirect call first does a 16-bit read at the pointer, which gives the target. It then does an 8-bit read at pointer+2, whose bits 7:0 give the new page. After that it continues as in R2, for six busy cycles in total.
- R4: A return does an 8-bit read at SP, then a 16-bit read at SP+1, then a jump to the word read. It takes three busy cycles and leaves the page register equal to the byte read.
- R5: A 16-bit push lowers SP by 2 and the page push lowers it by 1. A page pop raises SP by 1 and an address pop raises it by 2.
- R6: irq_block equals busy. A call or return request that arrives while busy is ignored, and the page register changes only during a sequence.
- R7: jump_valid is high for exactly one cycle, the last busy cycle, and jump_addr carries the target in that cycle.
- R8: A local address with bits 15:14 equal to 2'b10 is in the window. It maps to the extended address {page, addr[13:0]}, and in_window is high.
- R9: Any other local address maps to {6'b111111, addr}, and in_window is low.
- R10: When call_req and ret_req are both high in an idle cycle, the call is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a far call (sampled when idle) |
| call_ind | input | 1 | Call operands come through the pointer |
| ret_req | input | 1 | Start a far return (sampled when idle) |
| imm_page | input | 8 | Immediate new page |
| imm_target | input | 16 | Immediate target address |
| ret_addr | input | 16 | Return address to push |
| ptr | input | 16 | Pointer for indirect operands |
| mem_req | output | 1 | Stack/operand memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | 16-bit access when high, 8-bit when low |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the request cycle |
| page | output | 8 | Page register |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Sequence in progress |
| irq_block | output | 1 | Interrupt acceptance blocked |
| jump_valid | output | 1 | Jump indication |
| jump_addr | output | 16 | Jump target |
| loc_addr | input | 16 | Local address to translate |
| ext_addr | output | 22 | Translated extended address |
| in_window | output | 1 | loc_addr lies in the program window |

## Verification
The bench nests two calls and then unwinds them. A design that pushed the new page instead of the saved one, or that got the order of the pop reads wrong, would then return to the wrong page or address. An indirect call reads its page byte from pointer+2 and its target word from the pointer; an offset error or a swapped fetch order shows up as a mismatched read address or jump target. Requests are injected in the middle of a sequence, and a simultaneous call and return is raised while idle. A design that let these through would produce stray memory traffic or take the return instead of the call. The window edges 0x8000, 0xBFFF, 0x7FFF and 0xC000 catch an off-by-one in the window decode.

// File: rtl/pgcall_pkg.sv
package pgcall_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IND_ADR,
    ST_IND_PG,
    ST_SWAP,
    ST_PUSH_RA,
    ST_PUSH_PG,
    ST_POP_PG,
    ST_POP_RA,
    ST_JUMP
  } seq_state_t;
endpackage

// File: rtl/pgcall_ctrl.sv
module pgcall_ctrl
  import pgcall_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_req,
  input  logic       call_ind,
  input  logic       ret_req,
  output seq_state_t state
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (call_req)     state_d = call_ind ? ST_IND_ADR : ST_SWAP;
        else if (ret_req) state_d = ST_POP_PG;
      end
      ST_IND_ADR: state_d = ST_IND_PG;
      ST_IND_PG:  state_d = ST_SWAP;
      ST_SWAP:    state_d = ST_PUSH_RA;
      ST_PUSH_RA: state_d = ST_PUSH_PG;
      ST_PUSH_PG: state_d = ST_JUMP;
      ST_POP_PG:  state_d = ST_POP_RA;
      ST_POP_RA:  state_d = ST_JUMP;
      ST_JUMP:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pgcall_sp.sv
module pgcall_sp #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] SP_RESET = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec2,
  input  logic              dec1,
  input  logic              inc1,
  input  logic              inc2,
  output logic [ADDR_W-1:0] sp
);
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;

  assign sp_en = dec2 | dec1 | inc1 | inc2;

  always_comb begin
    sp_d = sp_q;
    if (dec2)      sp_d = sp_q - ADDR_W'(2);
    else if (dec1) sp_d = sp_q - ADDR_W'(1);
    else if (inc1) sp_d = sp_q + ADDR_W'(1);
    else if (inc2) sp_d = sp_q + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= ADDR_W'(SP_RESET);
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;
endmodule

// File: rtl/pgcall_xlate.sv
module pgcall_xlate #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 8,
  parameter int WIN_BITS = 14,
  parameter int WIN_SLOT = 2,
  localparam int SLOT_W  = ADDR_W - WIN_BITS,
  localparam int EXT_W   = PAGE_W + WIN_BITS
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] loc_addr,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              in_window
);
  assign in_window = (loc_addr[ADDR_W-1:WIN_BITS] == SLOT_W'(WIN_SLOT));

  always_comb begin
    if (in_window) ext_addr = {page, loc_addr[WIN_BITS-1:0]};
    else           ext_addr = {{(EXT_W-ADDR_W){1'b1}}, loc_addr};
  end
endmodule

// File: rtl/pgcall_seq.sv
module pgcall_seq
  import pgcall_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          PAGE_W   = 8,
  parameter int          WIN_BITS = 14,
  parameter int          WIN_SLOT = 2,
  parameter logic [15:0] SP_RESET = 16'h00F0,
  localparam int         EXT_W    = PAGE_W + WIN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              call_ind,
  input  logic              ret_req,
  input  logic [PAGE_W-1:0] imm_page,
  input  logic [ADDR_W-1:0] imm_target,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [ADDR_W-1:0] ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [PAGE_W-1:0] page,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              irq_block,
  output logic              jump_valid,
  output logic [ADDR_W-1:0] jump_addr,
  input  logic [ADDR_W-1:0] loc_addr,
  output logic [EXT_W-1:0]  ext_addr,
  output logic              in_window
);
  seq_state_t state;
  logic       accept_call;

  logic [PAGE_W-1:0] page_q, page_d, tmp_q, npg_q, npg_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d, ret_q, ptr_q;
  logic              page_en, tmp_en, npg_en, tgt_en;

  pgcall_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_ind(call_ind),
    .ret_req(ret_req), .state(state)
  );

  pgcall_sp #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .dec2(state == ST_PUSH_RA), .dec1(state == ST_PUSH_PG),
    .inc1(state == ST_POP_PG),  .inc2(state == ST_POP_RA),
    .sp(sp)
  );

  pgcall_xlate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_BITS(WIN_BITS),
                 .WIN_SLOT(WIN_SLOT)) u_xlate (
    .page(page_q), .loc_addr(loc_addr), .ext_addr(ext_addr), .in_window(in_window)
  );

  assign accept_call = (state == ST_IDLE) && call_req;

  // next-state of the datapath registers
  always_comb begin
    page_en = 1'b0;
    page_d  = page_q;
    tmp_en  = 1'b0;
    npg_en  = 1'b0;
    npg_d   = npg_q;
    tgt_en  = 1'b0;
    tgt_d   = tgt_q;
    case (state)
      ST_IDLE: if (call_req) begin
        npg_en = 1'b1; npg_d = imm_page;
        tgt_en = 1'b1; tgt_d = imm_target;
      end
      ST_IND_ADR: begin tgt_en = 1'b1; tgt_d = mem_rdata; end
      ST_IND_PG:  begin npg_en = 1'b1; npg_d = mem_rdata[PAGE_W-1:0]; end
      ST_SWAP:    begin tmp_en = 1'b1; page_en = 1'b1; page_d = npg_q; end
      ST_POP_PG:  begin page_en = 1'b1; page_d = mem_rdata[PAGE_W-1:0]; end
      ST_POP_RA:  begin tgt_en = 1'b1; tgt_d = mem_rdata; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      tmp_q  <= '0;
      npg_q  <= '0;
      tgt_q  <= '0;
      ret_q  <= '0;
      ptr_q  <= '0;
    end else begin
      if (page_en) page_q <= page_d;
      if (tmp_en)  tmp_q  <= page_q;
      if (npg_en)  npg_q  <= npg_d;
      if (tgt_en)  tgt_q  <= tgt_d;
      if (accept_call) begin
        ret_q <= ret_addr;
        ptr_q <= ptr;
      end
    end
  end

  // memory port, decoded from the step
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wide  = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    case (state)
      ST_IND_ADR: begin mem_req = 1'b1; mem_wide = 1'b1; mem_addr = ptr_q; end
      ST_IND_PG:  begin mem_req = 1'b1; mem_addr = ptr_q + ADDR_W'(2); end
      ST_PUSH_RA: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_wide = 1'b1;
        mem_addr = sp - ADDR_W'(2); mem_wdata = ret_q;
      end
      ST_PUSH_PG: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp - ADDR_W'(1);
        mem_wdata = {{(ADDR_W-PAGE_W){1'b0}}, tmp_q};
      end
      ST_POP_PG:  mem_req = 1'b1;
      ST_POP_RA:  begin mem_req = 1'b1; mem_wide = 1'b1; end
      default: ;
    endcase
  end

  assign page       = page_q;
  assign busy       = (state != ST_IDLE);
  assign irq_block  = busy;
  assign jump_valid = (state == ST_JUMP);
  assign jump_addr  = tgt_q;
endmodule

// File: rtl/pgcall_chk.sv
module pgcall_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int EXT_W  = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_wide,
  input logic [ADDR_W-1:0] sp,
  input logic [PAGE_W-1:0] page,
  input logic              busy,
  input logic              irq_block,
  input logic              jump_valid,
  input logic [ADDR_W-1:0] loc_addr,
  input logic [EXT_W-1:0]  ext_addr,
  input logic              in_window
);
  a_r5_wide_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_wide) |=> (sp == $past(sp) - ADDR_W'(2)));

  a_r5_page_push: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_wide) |=> (sp == $past(sp) - ADDR_W'(1)));

  a_r6_mem_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> irq_block);

  a_r6_page_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (page == $past(page)));

  a_r7_jump_last: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !busy);

  a_r7_jump_busy: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |-> (busy && !mem_req));

  a_r8_window_page: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (ext_addr[EXT_W-1:EXT_W-PAGE_W] == page));

  a_r9_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (ext_addr[ADDR_W-1:0] == loc_addr));
endmodule

bind pgcall_seq pgcall_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wide(mem_wide), .sp(sp), .page(page), .busy(busy),
  .irq_block(irq_block), .jump_valid(jump_valid), .loc_addr(loc_addr),
  .ext_addr(ext_addr), .in_window(in_window)
);

// File: tb/pgcall_seq_bench.sv
module pgcall_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_req = 1'b0, call_ind = 1'b0, ret_req = 1'b0;
  logic [7:0]  imm_page = '0;
  logic [15:0] imm_target = '0, ret_addr = '0, ptr = '0, loc_addr = '0;
  logic        mem_req, mem_we, mem_wide, busy, irq_block, jump_valid, in_window;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, sp, jump_addr;
  logic [7:0]  page;
  logic [21:0] ext_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgcall_seq u_pgcall_seq (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_ind(call_ind),
    .ret_req(ret_req), .imm_page(imm_page), .imm_target(imm_target),
    .ret_addr(ret_addr), .ptr(ptr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .page(page), .sp(sp), .busy(busy),
    .irq_block(irq_block), .jump_valid(jump_valid), .jump_addr(jump_addr),
    .loc_addr(loc_addr), .ext_addr(ext_addr), .in_window(in_window)
  );

  // bench memory, big-endian words, 256 bytes
  logic [7:0] bm [0:255];
  assign mem_rdata = mem_wide ? {bm[mem_addr[7:0]], bm[8'(mem_addr[7:0] + 8'd1)]}
                              : {8'h00, bm[mem_addr[7:0]]};

  typedef struct {
    bit          is_jump;
    bit          we;
    bit          wide;
    logic [15:0] addr;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t exq[$];

  int checks = 0, errors = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare traffic against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && (mem_req || jump_valid)) begin
      if (exq.size() == 0) begin
        check(1'b0, "R6", "unexpected activity", {mem_addr, 15'd0, jump_valid}, 32'd0);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (e.is_jump) begin
          check(jump_valid && !mem_req, e.req, "jump expected", {31'd0, jump_valid}, 32'd1);
          check(jump_addr == e.addr, e.req, "jump_addr", jump_addr, e.addr);
        end else begin
          check(mem_req && !jump_valid && mem_we == e.we && mem_wide == e.wide,
                e.req, "access kind", {mem_req, mem_we, mem_wide}, {1'b1, e.we, e.wide});
          check(mem_addr == e.addr, e.req, "mem_addr", mem_addr, e.addr);
          if (e.we) check(mem_wdata == e.data, e.req, "mem_wdata", mem_wdata, e.data);
        end
      end
      if (mem_req && mem_we) begin
        if (mem_wide) begin
          bm[mem_addr[7:0]] = mem_wdata[15:8];
          bm[8'(mem_addr[7:0] + 8'd1)] = mem_wdata[7:0];
        end else bm[mem_addr[7:0]] = mem_wdata[7:0];
      end
    end
  end

  // bench model of the architectural state
  logic [7:0]  m_page = 8'h00;
  logic [15:0] m_sp = 16'h00F0;
  logic [15:0] st_ra [$];
  logic [7:0]  st_pg [$];

  function automatic exp_t mk(bit j, bit we, bit wide, logic [15:0] a, logic [15:0] d, string r);
    exp_t e;
    e.is_jump = j; e.we = we; e.wide = wide; e.addr = a; e.data = d; e.req = r;
    return e;
  endfunction

  task automatic do_call(bit ind, logic [7:0] pg, logic [15:0] tgt, logic [15:0] ra,
                         logic [15:0] p, bit poke, bit both);
    logic [7:0]  pg_e;
    logic [15:0] tgt_e;
    int          n;
    int          swap_k;
    pg_e  = ind ? bm[p[7:0] + 8'd2] : pg;
    tgt_e = ind ? {bm[p[7:0]], bm[p[7:0] + 8'd1]} : tgt;
    if (ind) begin
      exq.push_back(mk(0, 0, 1, p, 16'h0, "R3"));
      exq.push_back(mk(0, 0, 0, p + 16'd2, 16'h0, "R3"));
    end
    exq.push_back(mk(0, 1, 1, m_sp - 16'd2, ra, "R2"));
    exq.push_back(mk(0, 1, 0, m_sp - 16'd3, {8'h00, m_page}, "R2"));
    exq.push_back(mk(1, 0, 0, tgt_e, 16'h0, "R7"));
    st_ra.push_back(ra);
    st_pg.push_back(m_page);
    swap_k = ind ? 3 : 1;
    call_ind = ind; imm_page = pg; imm_target = tgt; ret_addr = ra; ptr = p;
    call_req = 1'b1; ret_req = both;
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0;
    imm_page = 8'hEE; imm_target = 16'hDEAD; ret_addr = 16'hBEEF; ptr = 16'h0000;
    n = 0;
    while (busy) begin
      check(irq_block, "R6", "irq_block while busy", {31'd0, irq_block}, 32'd1);
      if (n == swap_k - 1)
        check(page == m_page, "R2", "page before swap", page, m_page);
      if (n == swap_k)
        check(page == pg_e, "R2", "page after swap", page, pg_e);
      call_req = poke && (n == 1);
      ret_req  = poke && (n == 1);
      n++;
      @(negedge clk);
    end
    call_req = 1'b0; ret_req = 1'b0;
    m_page = pg_e;
    m_sp   = m_sp - 16'd3;
    check(n == (ind ? 6 : 4), ind ? "R3" : "R2", "busy cycles", n, ind ? 6 : 4);
    check(page == m_page, "R2", "page after call", page, m_page);
    check(sp == m_sp, "R5", "sp after call", sp, m_sp);
    @(negedge clk);
  endtask

  task automatic do_ret();
    logic [15:0] ra;
    logic [7:0]  pg;
    int          n;
    ra = st_ra.pop_back();
    pg = st_pg.pop_back();
    exq.push_back(mk(0, 0, 0, m_sp, 16'h0, "R4"));
    exq.push_back(mk(0, 0, 1, m_sp + 16'd1, 16'h0, "R4"));
    exq.push_back(mk(1, 0, 0, ra, 16'h0, "R4"));
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    m_page = pg;
    m_sp   = m_sp + 16'd3;
    check(n == 3, "R4", "return busy cycles", n, 3);
    check(page == m_page, "R4", "page restored", page, m_page);
    check(sp == m_sp, "R5", "sp after return", sp, m_sp);
    @(negedge clk);
  endtask

  task automatic xl(logic [15:0] a, logic [21:0] exp_ext, bit exp_win, string r);
    loc_addr = a;
    #1;
    check(ext_addr == exp_ext, r, "ext_addr", ext_addr, exp_ext);
    check(in_window == exp_win, r, "in_window", in_window, exp_win);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WD", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bm[i] = 8'(i * 7 + 3);
    bm[8'h40] = 8'h12; bm[8'h41] = 8'h34; bm[8'h42] = 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state, during and after reset
    check(page == 8'h00 && sp == 16'h00F0, "R1", "reset page/sp", {page, sp}, {8'h00, 16'h00F0});
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !irq_block && !mem_req && !jump_valid, "R1", "idle outputs",
          {busy, irq_block, mem_req, jump_valid}, 4'b0);
    check(page == 8'h00 && sp == 16'h00F0, "R1", "page/sp after release", {page, sp}, {8'h00, 16'h00F0});

    // R8 / R9 translation at page 0
    xl(16'h8000, 22'h000000, 1'b1, "R8");
    xl(16'h7FFF, 22'h3F7FFF, 1'b0, "R9");

    // R2 direct call, nested with R3 indirect call and a poke (R6)
    do_call(1'b0, 8'h21, 16'h9000, 16'h1111, 16'h0000, 1'b0, 1'b0);
    xl(16'hBFFF, {8'h21, 14'h3FFF}, 1'b1, "R8");
    xl(16'hC000, 22'h3FC000, 1'b0, "R9");
    do_call(1'b1, 8'h00, 16'h0000, 16'h2222, 16'h0040, 1'b1, 1'b0);
    xl(16'h8123, {8'h5A, 14'h0123}, 1'b1, "R8");
    // unwind, R4
    do_ret();
    do_ret();
    check(page == 8'h00, "R4", "page after full unwind", page, 8'h00);
    // R10 call and return requested together
    do_call(1'b0, 8'h7C, 16'hA55A, 16'h3333, 16'h0000, 1'b1, 1'b1);
    do_ret();
    // R6 idle with no request: page and sp stay put
    repeat (3) @(negedge clk);
    check(page == m_page && sp == m_sp, "R6", "idle stability", {page, sp}, {m_page, m_sp});
    check(exq.size() == 0, "R7", "scoreboard drained", exq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule